// File: doc/BRIEF.md
# Four-Bit Float Dequantizer With Shared Scale

This block turns one 4-bit floating-point code (1 sign bit, 2 exponent bits, 1 mantissa bit) into an IEEE single-precision value. It multiplies the code by a power of two taken from an 8-bit shared scale exponent, which is biased by 127. The scale is applied by adding to the exponent, so a result is exact wherever it can be represented. Results that fall below the normal single-precision range are placed in the subnormal range and rounded to nearest, ties to even. Results that fall below the smallest subnormal become signed zero. Results that go past the largest finite exponent become signed infinity. The all-ones scale value is reserved and marks the whole group as not-a-number.

A caller presents a code, a scale and a valid strobe in one cycle. The value appears one clock later on a registered output, together with its own valid flag. Between accepted inputs the registered value stays unchanged.

Top module: `fp4_dequant`

## Requirements
- R1: With scale 127, magnitudes 0..7 (code bits [2:0]) give 0x00000000, 0x3F000000, 0x3F800000, 0x3FC00000, 0x40000000, 0x40400000, 0x40800000, 0x40C00000, and code bit 3 is copied to output bit 31 for every scale.
- R2: Scale 0xFF gives a quiet NaN: output bit 31 is the code sign, and bits [30:0] are 0x7FC00000 ORed with code bit 0 placed at bit 22. This takes priority over every other case.
- R3: A code magnitude of zero (bits [2:0] = 000) gives signed zero (bits [30:0] = 0) for every scale other than 0xFF.
- R4: A code with exponent field [2:1] = 00 and mantissa bit [0] = 1 is the value 0.5, whatever its sign bit. So code 0x9 gives -0.5 x 2^(scale-127).
- R5: For a nonzero code, define E = code exponent + scale - 127. The code exponent is field [2:1] minus 1, or -1 for the 0.5 code. When E is in -126..127, the output exponent field is E+127, and the fraction holds the code mantissa at bit 22 with zeros below.
- R6: When E is 128 or more, the output is signed infinity (bits [30:0] = 0x7F800000).
- R7: When E is in -149..-127, the output exponent field is 0. The significand 1.m is shifted right by -126-E into the fraction and rounded to nearest even. A rounding carry sets the exponent field to 1. When E is below -149, the output is signed zero.
- R8: `out_valid` equals `in_valid` of the previous cycle. `out_value` is loaded only in cycles where `in_valid` is high, and otherwise holds its value.
- R9: While reset is high, and in the first cycle after it, `out_valid` is 0 and `out_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe |
| in_code | input | 4 | Code: sign [3], exponent [2:1], mantissa [0] |
| in_scale | input | SCALE_W (8) | Shared scale exponent, bias 127, 0xFF reserved |
| out_valid | output | 1 | Registered result valid |
| out_value | output | 1+EXP_W+FRAC_W (32) | Registered single-precision result |

## Verification
Several classifications can hold for the same input. A reserved scale can arrive with a zero code, and an out-of-range exponent can arrive with a zero code. In each case the priority order must pick one class. The full sweep of every code against every scale covers all of these overlaps. In it, scale 0xFF is paired with zero-magnitude codes and with codes that would overflow, and scale 0 is paired with the subnormal 0.5 code of either sign. Each output is judged against a reference computed from plain exponent arithmetic. A NaN must win over zero and over infinity, and a zero magnitude must win over any exponent range.

// File: rtl/fp4dq_pkg.sv
package fp4dq_pkg;

  // Output classes, chosen in priority order by pick_kind.
  typedef enum logic [2:0] {
    K_NORM,
    K_SUB,
    K_FLUSH,
    K_INF,
    K_ZERO,
    K_NAN
  } kind_t;

  // Unpacked view of one 4-bit code.
  typedef struct packed {
    logic              sign;
    logic              mag_zero;
    logic              is_sub;
    logic signed [2:0] uexp;
    logic              man;
  } e2m1_t;

  function automatic e2m1_t decode_e2m1(input logic [3:0] c);
    e2m1_t d;
    d.sign     = c[3];
    d.mag_zero = (c[2:0] == 3'b000);
    // Only the exponent field and mantissa bit decide this; the sign bit is ignored.
    d.is_sub   = (c[2:1] == 2'b00) && c[0];
    d.uexp     = $signed({1'b0, c[2:1]}) - 3'sd1;
    d.man      = c[0];
    if (d.is_sub) begin
      d.uexp = -3'sd1;
      d.man  = 1'b0;
    end
    return d;
  endfunction

  function automatic kind_t pick_kind(input logic nan, input logic zero,
                                      input logic over, input logic flush,
                                      input logic sub);
    kind_t k;
    if (nan)        k = K_NAN;
    else if (zero)  k = K_ZERO;
    else if (over)  k = K_INF;
    else if (flush) k = K_FLUSH;
    else if (sub)   k = K_SUB;
    else            k = K_NORM;
    return k;
  endfunction

endpackage

// File: rtl/fp4dq_decode.sv
module fp4dq_decode
  import fp4dq_pkg::*;
(
  input  logic [3:0]        code,
  output logic              sign,
  output logic              mag_zero,
  output logic              is_sub,
  output logic signed [2:0] uexp,
  output logic              man
);

  e2m1_t d;

  always_comb begin
    d = decode_e2m1(code);
  end

  assign sign     = d.sign;
  assign mag_zero = d.mag_zero;
  assign is_sub   = d.is_sub;
  assign uexp     = d.uexp;
  assign man      = d.man;

endmodule

// File: rtl/fp4dq_scale.sv
module fp4dq_scale #(
  parameter int SCALE_W = 8,
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int ZW      = 11
) (
  input  logic signed [2:0]    uexp,
  input  logic [SCALE_W-1:0]   scale,
  output logic signed [ZW-1:0] sexp,
  output logic                 nan_scale,
  output logic                 over,
  output logic                 under,
  output logic                 flush
);

  localparam int SCALE_BIAS = (1 << (SCALE_W - 1)) - 1;
  localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [ZW-1:0] SB      = ZW'(SCALE_BIAS);
  localparam logic signed [ZW-1:0] MAX_E   = ZW'(BIAS);
  localparam logic signed [ZW-1:0] MIN_E   = ZW'(1 - BIAS);
  localparam logic signed [ZW-1:0] FLUSH_E = ZW'(1 - BIAS - FRAC_W);

  logic signed [ZW-1:0] ue_x;
  logic signed [ZW-1:0] sc_x;

  assign ue_x = ZW'(uexp);
  assign sc_x = $signed(ZW'(scale));
  assign sexp = ue_x + sc_x - SB;

  assign nan_scale = &scale;
  assign over      = sexp > MAX_E;
  assign under     = sexp < MIN_E;
  assign flush     = sexp < FLUSH_E;

endmodule

// File: rtl/fp4dq_pack.sv
module fp4dq_pack
  import fp4dq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int ZW     = 11
) (
  input  kind_t                     kind,
  input  logic                      sign,
  input  logic                      man,
  input  logic                      raw_man,
  input  logic signed [ZW-1:0]      sexp,
  output logic [EXP_W+FRAC_W:0]     value
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int XW   = 2 * FRAC_W + 3;
  localparam logic signed [ZW-1:0] MIN_E = ZW'(1 - BIAS);
  localparam logic signed [ZW-1:0] ZB    = ZW'(BIAS);

  logic [FRAC_W:0]   sig;
  logic [ZW-1:0]     shamt;
  logic [XW-2:0]     wide_lo;
  logic [FRAC_W-1:0] field;
  logic              guard;
  logic              sticky;
  logic              rnd_up;
  logic [FRAC_W:0]   rnd;
  logic [EXP_W-1:0]  biased;

  // Significand 1.m placed with the hidden bit on top.
  assign sig     = {1'b1, man, {(FRAC_W - 1){1'b0}}};
  assign shamt   = $unsigned(MIN_E - sexp);
  assign wide_lo = (XW - 1)'({sig, {(FRAC_W + 2){1'b0}}} >> shamt);
  assign field   = wide_lo[XW-2 -: FRAC_W];
  assign guard   = wide_lo[XW-2-FRAC_W];
  assign sticky  = |wide_lo[XW-3-FRAC_W:0];
  assign rnd_up  = guard & (sticky | field[0]);
  // A carry out of the fraction lands in the exponent LSB.
  assign rnd     = {1'b0, field} + (FRAC_W + 1)'(rnd_up);
  assign biased  = EXP_W'(sexp + ZB);

  always_comb begin
    unique case (kind)
      K_NAN:   value = {sign, {EXP_W{1'b1}}, 1'b1 | raw_man, {(FRAC_W - 1){1'b0}}};
      K_INF:   value = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      K_SUB:   value = {sign, {(EXP_W - 1){1'b0}}, rnd};
      K_NORM:  value = {sign, biased, man, {(FRAC_W - 1){1'b0}}};
      default: value = {sign, {(EXP_W + FRAC_W){1'b0}}};
    endcase
  end

endmodule

// File: rtl/fp4_dequant.sv
module fp4_dequant
  import fp4dq_pkg::*;
#(
  parameter int SCALE_W = 8,
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [3:0]             in_code,
  input  logic [SCALE_W-1:0]     in_scale,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  out_value
);

  localparam int OUT_W = 1 + EXP_W + FRAC_W;
  localparam int ZW    = ((SCALE_W > EXP_W) ? SCALE_W : EXP_W) + 3;

  logic              d_sign;
  logic              d_mag_zero;
  logic              d_is_sub;
  logic signed [2:0] d_uexp;
  logic              d_man;

  logic signed [ZW-1:0] sexp;
  logic ev_nan;
  logic ev_zero;
  logic ev_over;
  logic ev_under;
  logic ev_flush;
  logic ev_sub;
  kind_t kind;
  logic [OUT_W-1:0] value_c;

  fp4dq_decode u_dec (
    .code     (in_code),
    .sign     (d_sign),
    .mag_zero (d_mag_zero),
    .is_sub   (d_is_sub),
    .uexp     (d_uexp),
    .man      (d_man)
  );

  fp4dq_scale #(
    .SCALE_W (SCALE_W),
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .ZW      (ZW)
  ) u_scl (
    .uexp      (d_uexp),
    .scale     (in_scale),
    .sexp      (sexp),
    .nan_scale (ev_nan),
    .over      (ev_over),
    .under     (ev_under),
    .flush     (ev_flush)
  );

  assign ev_zero = d_mag_zero;
  assign kind    = pick_kind(ev_nan, ev_zero, ev_over, ev_flush, ev_under);
  assign ev_sub  = (kind == K_SUB);

  fp4dq_pack #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .ZW     (ZW)
  ) u_pack (
    .kind    (kind),
    .sign    (d_sign),
    .man     (d_man),
    .raw_man (in_code[0]),
    .sexp    (sexp),
    .value   (value_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= value_c;
    end
  end

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_value[OUT_W-1] == $past(in_code[3])); // R1
  AST_NAN_SCALE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_nan) |=> (&out_value[OUT_W-2 -: EXP_W+1])); // R2
  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_zero && !ev_nan) |=> (out_value[OUT_W-2:0] == '0)); // R3
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_over && !ev_nan && !ev_zero)
      |=> (out_value[OUT_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})); // R6
  AST_SUB_EXP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ev_sub) |=> (out_value[OUT_W-2 -: EXP_W] <= EXP_W'(1))); // R7
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_value)); // R8

endmodule

// File: tb/sim_fp4_dequant.sv
`timescale 1ns/1ps
module sim_fp4_dequant;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_code;
  logic [7:0]  in_scale;
  logic        out_valid;
  logic [31:0] out_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fp4_dequant u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_scale  (in_scale),
    .out_valid (out_valid),
    .out_value (out_value)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  code;
    logic [7:0]  scale;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 4'h1, 8'd127, 32'h3F000000},  // R1
    '{4'd1, 4'h3, 8'd127, 32'h3FC00000},  // R1
    '{4'd1, 4'h5, 8'd127, 32'h40400000},  // R1
    '{4'd1, 4'hF, 8'd127, 32'hC0C00000},  // R1
    '{4'd4, 4'h9, 8'd127, 32'hBF000000},  // R4
    '{4'd4, 4'h9, 8'd130, 32'hC0800000},  // R4
    '{4'd3, 4'h8, 8'd0,   32'h80000000},  // R3
    '{4'd3, 4'h0, 8'd200, 32'h00000000},  // R3
    '{4'd2, 4'h7, 8'd255, 32'h7FC00000},  // R2
    '{4'd2, 4'h8, 8'd255, 32'hFFC00000},  // R2 over zero
    '{4'd6, 4'h7, 8'd254, 32'h7F800000},  // R6
    '{4'd6, 4'hC, 8'd254, 32'hFF800000},  // R6
    '{4'd5, 4'h3, 8'd254, 32'h7F400000},  // R5 top exponent
    '{4'd5, 4'h2, 8'd1,   32'h00800000},  // R5 lowest normal
    '{4'd7, 4'h3, 8'd0,   32'h00600000},  // R7
    '{4'd7, 4'h1, 8'd0,   32'h00200000},  // R7
    '{4'd7, 4'hB, 8'd0,   32'h80600000},  // R7
    '{4'd5, 4'h4, 8'd0,   32'h00800000}   // R5
  };

  function automatic logic [31:0] ref_f32(input logic [3:0] c, input int s);
    logic        sg;
    int          mag, e, m, ee;
    logic [23:0] sig;
    sg  = c[3];
    mag = int'(c[2:0]);
    if (s == 255) return {sg, 31'h7FC00000 | (31'(c[0]) << 22)};
    if (mag == 0) return {sg, 31'h0};
    if (mag == 1) begin
      e = -1; m = 0;
    end else begin
      e = (mag / 2) - 1; m = mag % 2;
    end
    ee = e + s - 127;
    if (ee > 127) return {sg, 8'hFF, 23'h0};
    if (ee >= -126) return {sg, 8'(ee + 127), 1'(m), 22'h0};
    if (ee >= -149) begin
      sig = {1'b1, 1'(m), 22'h0};
      sig = sig >> (-126 - ee);
      return {sg, 8'h00, sig[22:0]};
    end
    return {sg, 31'h0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [7:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = c;
    in_scale = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_code = 4'h7; in_scale = 8'd127;
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", {31'h0, out_valid}, 32'h0);
    chk("R9 out_value in reset", out_value, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 out_valid after reset", {31'h0, out_valid}, 32'h0);
    chk("R9 out_value after reset", out_value, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].code, VECS[i].scale);
      chk($sformatf("R%0d valid vec%0d", VECS[i].req, i), {31'h0, out_valid}, 32'h1);
      chk($sformatf("R%0d value vec%0d", VECS[i].req, i), out_value, VECS[i].exp);
    end

    // R8: idle cycle keeps the last value and drops valid
    apply(4'h5, 8'd127);
    @(negedge clk);
    in_valid = 1'b0; in_code = 4'h7; in_scale = 8'd254;
    @(negedge clk);
    chk("R8 valid low when idle", {31'h0, out_valid}, 32'h0);
    chk("R8 value held when idle", out_value, 32'h40400000);
    @(negedge clk);
    chk("R8 value still held", out_value, 32'h40400000);

    // Full sweep, every code against every scale (R1..R7 by exponent arithmetic)
    for (int s = 0; s < 256; s++) begin
      for (int c = 0; c < 16; c++) begin
        apply(4'(c), 8'(s));
        if (out_value !== ref_f32(4'(c), s))
          $display("sweep mismatch code=%h scale=%0d", c, s);
        chk((s == 255) ? "R2 sweep" : ((c % 8) == 0) ? "R3 sweep" : "R5 sweep",
            out_value, ref_f32(4'(c), s));
      end
    end

    // R9: reset clears a loaded value
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 value cleared by reset", out_value, 32'h0);
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule